// File: doc/BRIEF.md
# Banked GPIO Expander with Edge Interrupts

This block is a register-mapped port of general-purpose pins, organised in banks of eight (three banks and 24 pins by default). A host reaches it through a plain synchronous register bus with an address, a write strobe, a read strobe, write data and registered read data. Every pin can be turned into an output. Its output level is raised or lowered through two separate write-one registers, and its live level can be read back at any time.

Incoming pin levels pass through a two-flop synchroniser before any use. Each pin can be armed to catch rising transitions, falling transitions, or both. A caught transition sets a sticky per-pin edge flag and a sticky status bit. A single active-high interrupt line is raised whenever a status bit is set and the matching interrupt-enable bit is 1. Flags and status bits are cleared by writing ones back to them.

The address is split into a group code and a bank slot. Slot 0 always holds the most significant bank, so a burst read through consecutive slots returns the high bank first.

Top module: `gpx_top`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all 0), the output latches read 0, `irq` is 0, and every enable, flag and status register reads 0.
- R2: Writing group SET (code 2) ORs the written byte into the bank's output latch. Zero bits leave the latch unchanged. Reading SET or CLR returns the latch, which drives `pin_out`.
- R3: Writing group CLR (code 3) clears every latch bit written as 1 and leaves the bits written as 0 unchanged.
- R4: Group DIR (code 1) holds one bit per pin. A 1 makes the pin an output (`pin_oe` bit high) and a 0 makes it an input.
- R5: Reading group MON (code 0) returns the synchronised level of each pin, whether it is an input or an output. The level becomes visible two clock edges after the pin changes.
- R6: Group RISE (code 4) arms rising-edge detection and group FALL (code 5) arms falling-edge detection. Setting both catches either edge, and a pin with neither set never records an edge.
- R7: `irq` is 1 one cycle after any pin has both its STAT bit (code 8) and its IEN bit (code 7) set. A set status bit with IEN at 0 leaves `irq` low.
- R8: The EDGE (code 6) and STAT (code 8) bits are cleared by writing 1. Writing 0 leaves them unchanged.
- R9: The address is {group[3:0], slot[1:0]}, and slot s selects bank NUM_BANKS-1-s, so slot 0 is the most significant bank. A slot with no bank reads 0, and a write to one bank leaves the other banks unchanged.
- R10: If an armed edge and a write-one clear hit the same STAT bit in the same cycle, the bit stays set.
- R11: A detected edge sets both the EDGE flag and the STAT bit. Clearing one leaves the other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Register address: group code and bank slot |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the following cycle |
| rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Pin levels seen at the pads |
| pin_out | output | 24 | Output latch values |
| pin_oe | output | 24 | Output enable per pin (1 = output) |
| irq | output | 1 | Interrupt request, active high |

## Verification
A previous-sample register that is not updated, or one that is inverted, would show up as a missing or extra EDGE or STAT bit on the next read, two to three cycles after the pin toggles. A status bit stuck at 1 holds `irq` high one cycle after IEN is set, and the next STAT read shows the stuck bit. Two faults appear directly at `rdata` in the cycle after the read strobe: a bank decode that runs the wrong way, and a clear that wins over a same-cycle edge.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BANK_W = 8;
  localparam int GRP_W  = 4;
  localparam int SLOT_W = 2;
  localparam int ADDR_W = GRP_W + SLOT_W;

  typedef enum logic [GRP_W-1:0] {
    GRP_MON  = 4'd0,
    GRP_DIR  = 4'd1,
    GRP_SET  = 4'd2,
    GRP_CLR  = 4'd3,
    GRP_RISE = 4'd4,
    GRP_FALL = 4'd5,
    GRP_EDGE = 4'd6,
    GRP_IEN  = 4'd7,
    GRP_STAT = 4'd8
  } grp_e;

  // Armed transitions seen between the previous and current sample.
  function automatic logic [BANK_W-1:0] edge_hits(input logic [BANK_W-1:0] now,
                                                  input logic [BANK_W-1:0] prev,
                                                  input logic [BANK_W-1:0] ren,
                                                  input logic [BANK_W-1:0] fen);
    return (now & ~prev & ren) | (~now & prev & fen);
  endfunction

  // Sticky bit update: a new hit takes precedence over a write-one clear.
  function automatic logic [BANK_W-1:0] sticky_next(input logic [BANK_W-1:0] cur,
                                                    input logic [BANK_W-1:0] clr,
                                                    input logic [BANK_W-1:0] hit);
    return (cur & ~clr) | hit;
  endfunction

  // Slot holding a given bank: the most significant bank sits in slot 0.
  function automatic logic [SLOT_W-1:0] bank_slot(input int bank, input int nbanks);
    return SLOT_W'(nbanks - 1 - bank);
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  grp_e              grp,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] lvl,
  output logic [BANK_W-1:0] dir_o,
  output logic [BANK_W-1:0] out_o,
  output logic [BANK_W-1:0] ren_o,
  output logic [BANK_W-1:0] fen_o,
  output logic [BANK_W-1:0] ien_o,
  output logic [BANK_W-1:0] flag_o,
  output logic [BANK_W-1:0] stat_o,
  output logic [BANK_W-1:0] hit_o
);
  logic [BANK_W-1:0] dir_q, out_q, ren_q, fen_q, ien_q;
  logic [BANK_W-1:0] prev_q, flag_q, stat_q;
  logic [BANK_W-1:0] flag_clr, stat_clr, hit;

  assign hit      = edge_hits(lvl, prev_q, ren_q, fen_q);
  assign flag_clr = (wr_strobe && grp == GRP_EDGE) ? wdata : '0;
  assign stat_clr = (wr_strobe && grp == GRP_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      ien_q <= '0;
    end else if (wr_strobe) begin
      case (grp)
        GRP_DIR:  dir_q <= wdata;
        GRP_SET:  out_q <= out_q | wdata;
        GRP_CLR:  out_q <= out_q & ~wdata;
        GRP_RISE: ren_q <= wdata;
        GRP_FALL: fen_q <= wdata;
        GRP_IEN:  ien_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl;
      flag_q <= sticky_next(flag_q, flag_clr, hit);
      stat_q <= sticky_next(stat_q, stat_clr, hit);
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign ren_o  = ren_q;
  assign fen_o  = fen_q;
  assign ien_o  = ien_q;
  assign flag_o = flag_q;
  assign stat_o = stat_q;
  assign hit_o  = hit;
endmodule

// File: rtl/gpx_top.sv
module gpx_top
  import gpx_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BANK_W-1:0]             wdata,
  input  logic                          wr_en,
  input  logic                          rd_en,
  output logic [BANK_W-1:0]             rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   pin_in,
  output logic [NUM_BANKS*BANK_W-1:0]   pin_out,
  output logic [NUM_BANKS*BANK_W-1:0]   pin_oe,
  output logic                          irq
);
  localparam int NPINS = NUM_BANKS * BANK_W;

  grp_e                                grp;
  logic [SLOT_W-1:0]                   slot;
  logic [NUM_BANKS-1:0]                bank_hit;
  logic [NPINS-1:0]                    lvl_all;
  logic [NUM_BANKS-1:0][BANK_W-1:0]    dir_b, out_b, ren_b, fen_b, ien_b, flag_b, stat_b, hit_b;
  logic [NPINS-1:0]                    stat_all, ien_all, hit_all, out_all;
  logic [NPINS-1:0]                    set_wmask, clr_wmask;
  logic [BANK_W-1:0]                   rd_mux, rdata_q;
  logic                                irq_q;

  assign grp  = grp_e'(addr[ADDR_W-1:SLOT_W]);
  assign slot = addr[SLOT_W-1:0];

  gpx_sync #(.WIDTH(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (lvl_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = (slot == bank_slot(b, NUM_BANKS));

    gpx_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_strobe (wr_en && bank_hit[b]),
      .grp       (grp),
      .wdata     (wdata),
      .lvl       (lvl_all[b*BANK_W +: BANK_W]),
      .dir_o     (dir_b[b]),
      .out_o     (out_b[b]),
      .ren_o     (ren_b[b]),
      .fen_o     (fen_b[b]),
      .ien_o     (ien_b[b]),
      .flag_o    (flag_b[b]),
      .stat_o    (stat_b[b]),
      .hit_o     (hit_b[b])
    );

    assign stat_all[b*BANK_W +: BANK_W]  = stat_b[b];
    assign ien_all[b*BANK_W +: BANK_W]   = ien_b[b];
    assign hit_all[b*BANK_W +: BANK_W]   = hit_b[b];
    assign out_all[b*BANK_W +: BANK_W]   = out_b[b];
    assign pin_oe[b*BANK_W +: BANK_W]    = dir_b[b];
    assign set_wmask[b*BANK_W +: BANK_W] = (wr_en && bank_hit[b] && grp == GRP_SET) ? wdata : '0;
    assign clr_wmask[b*BANK_W +: BANK_W] = (wr_en && bank_hit[b] && grp == GRP_CLR) ? wdata : '0;
  end

  assign pin_out = out_all;

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (grp)
          GRP_MON:  rd_mux = lvl_all[b*BANK_W +: BANK_W];
          GRP_DIR:  rd_mux = dir_b[b];
          GRP_SET:  rd_mux = out_b[b];
          GRP_CLR:  rd_mux = out_b[b];
          GRP_RISE: rd_mux = ren_b[b];
          GRP_FALL: rd_mux = fen_b[b];
          GRP_EDGE: rd_mux = flag_b[b];
          GRP_IEN:  rd_mux = ien_b[b];
          GRP_STAT: rd_mux = stat_b[b];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rd_mux;
      irq_q <= |(stat_all & ien_all);
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] stat_all,
  input logic [NPINS-1:0] ien_all,
  input logic [NPINS-1:0] hit_all,
  input logic [NPINS-1:0] set_wmask,
  input logic [NPINS-1:0] clr_wmask
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq)); // R1

  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wmask != '0) |=> ((pin_out & $past(set_wmask)) == $past(set_wmask))); // R2

  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wmask != '0) |=> ((pin_out & $past(pin_out)) == $past(pin_out))); // R2

  AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wmask != '0) |=> ((pin_out & $past(clr_wmask)) == '0)); // R3

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_all & ien_all) != '0) |=> irq); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_all & ien_all) == '0) |=> !irq); // R7

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_all != '0) |=> ((stat_all & $past(hit_all)) == $past(hit_all))); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_all & ~$past(stat_all) & ~$past(hit_all)) == '0)); // R6
endmodule

bind gpx_top gpx_checker #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .stat_all  (stat_all),
  .ien_all   (ien_all),
  .hit_all   (hit_all),
  .set_wmask (set_wmask),
  .clr_wmask (clr_wmask)
);

// File: tb/gpx_top_tb.sv
module gpx_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int NP = NB * 8;
  // Group codes and slots, from the requirements
  localparam logic [3:0] G_MON = 4'd0, G_DIR = 4'd1, G_SET = 4'd2, G_CLR = 4'd3,
                         G_RISE = 4'd4, G_FALL = 4'd5, G_EDGE = 4'd6, G_IEN = 4'd7,
                         G_STAT = 4'd8;
  // vector: {is_write, group, slot, data, expected}
  localparam int NVEC = 16;
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, G_DIR,  2'd2, 8'h0F, 8'h00},
    {1'b0, G_DIR,  2'd2, 8'h00, 8'h0F},
    {1'b1, G_SET,  2'd2, 8'h05, 8'h00},
    {1'b0, G_SET,  2'd2, 8'h00, 8'h05},
    {1'b1, G_SET,  2'd2, 8'h00, 8'h00},
    {1'b0, G_SET,  2'd2, 8'h00, 8'h05},
    {1'b1, G_CLR,  2'd2, 8'h04, 8'h00},
    {1'b0, G_CLR,  2'd2, 8'h00, 8'h01},
    {1'b1, G_IEN,  2'd0, 8'hA5, 8'h00},
    {1'b0, G_IEN,  2'd0, 8'h00, 8'hA5},
    {1'b0, G_IEN,  2'd2, 8'h00, 8'h00},
    {1'b0, G_IEN,  2'd3, 8'h00, 8'h00},
    {1'b1, G_RISE, 2'd1, 8'h3C, 8'h00},
    {1'b0, G_RISE, 2'd1, 8'h00, 8'h3C},
    {1'b0, G_FALL, 2'd1, 8'h00, 8'h00},
    {1'b0, G_MON,  2'd2, 8'h00, 8'h01}
  };
  localparam string VTAG [NVEC] = '{"R4", "R4", "R2", "R2", "R2", "R2", "R3", "R3",
                                    "R9", "R9", "R9", "R9", "R6", "R6", "R9", "R5"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe, ext;
  logic          irq;
  int            checks = 0;
  int            fails = 0;
  logic [7:0]    rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pad model: an output pin reads back its own drive
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpx_top #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] g, input logic [1:0] s, input logic [7:0] d);
    addr = {g, s}; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] g, input logic [1:0] s, output logic [7:0] d);
    addr = {g, s}; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ext = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    ext = '0;
    do_reset();
    // R1: reset state at the ports and registers
    check("R1 oe", pin_oe, 0);
    check("R1 out", pin_out, 0);
    check("R1 irq", irq, 0);
    for (int g = 1; g <= 8; g++) begin
      bus_rd(4'(g), 2'd1, rv);
      check("R1 reg", rv, 0);
    end

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][22]) bus_wr(VEC[i][21:18], VEC[i][17:16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][21:18], VEC[i][17:16], rv);
        check(VTAG[i], rv, VEC[i][7:0]);
      end
    end
    check("R4 oe", pin_oe, 24'h00000F);
    check("R2 out", pin_out, 24'h000001);

    // R5: monitor of an input pin, after the two-stage delay
    ext[20] = 1'b1;
    idle(3);
    bus_rd(G_MON, 2'd0, rv);
    check("R5 input level", rv, 8'h10);

    // Edge detection on bank 1
    do_reset();
    bus_wr(G_RISE, 2'd1, 8'h05);
    bus_wr(G_FALL, 2'd1, 8'h06);
    ext[11:8] = 4'hF;
    idle(4);
    bus_rd(G_EDGE, 2'd1, rv);
    check("R6 rising", rv, 8'h05);
    ext[11:8] = 4'h0;
    idle(4);
    bus_rd(G_EDGE, 2'd1, rv);
    check("R6 falling", rv, 8'h07);
    bus_rd(G_STAT, 2'd1, rv);
    check("R11 stat", rv, 8'h07);
    check("R7 masked irq", irq, 0);
    bus_wr(G_IEN, 2'd1, 8'h02);
    idle(2);
    check("R7 irq", irq, 1);
    bus_wr(G_STAT, 2'd1, 8'h00);
    bus_rd(G_STAT, 2'd1, rv);
    check("R8 zero write", rv, 8'h07);
    bus_wr(G_STAT, 2'd1, 8'h02);
    bus_rd(G_STAT, 2'd1, rv);
    check("R8 w1c", rv, 8'h05);
    idle(1);
    check("R7 irq drop", irq, 0);
    bus_rd(G_EDGE, 2'd1, rv);
    check("R11 flag kept", rv, 8'h07);
    bus_wr(G_EDGE, 2'd1, 8'h07);
    bus_rd(G_EDGE, 2'd1, rv);
    check("R8 edge w1c", rv, 8'h00);
    bus_rd(G_STAT, 2'd1, rv);
    check("R11 stat kept", rv, 8'h05);

    // R10: rising edge on pin 8 meets a clear of its status bit
    ext[8] = 1'b1;
    idle(1);
    idle(1);
    bus_wr(G_STAT, 2'd1, 8'h01);
    bus_rd(G_STAT, 2'd1, rv);
    check("R10 edge wins", rv, 8'h05);
    bus_wr(G_STAT, 2'd1, 8'h01);
    bus_rd(G_STAT, 2'd1, rv);
    check("R8 plain clear", rv, 8'h04);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule